// File: doc/BRIEF.md
# Receive Descriptor DMA Engine

This block moves received frames from a MAC-side word stream into host memory. Host software builds a linked chain of four-word receive descriptors. Each descriptor carries an ownership flag, a buffer size, a buffer address and the address of the next descriptor. Once receive is enabled, the engine loads the first descriptor from the base-address input and keeps one descriptor fetched ahead of the traffic. Incoming words go into the described buffer. When the buffer fills, or when the frame ends, the engine writes word 0 back with ownership returned to the host.

A descriptor that the host still owns puts the engine into a suspended state and raises a sticky buffer-unavailable flag. Each new frame that arrives during suspension makes the engine read the same descriptor again. If the host has handed that descriptor over in the meantime, the frame is received. If not, the frame is pulled from the stream without any memory write and a missed-frame counter advances.

Top module: `rx_desc_dma`

## Requirements
- R1: When `rx_enable` is set from the idle state, the first memory read is word 0 of the descriptor at `ring_base`. Each later stop and restart reloads the address from `ring_base`.
- R2: A descriptor is engine-owned when bit 31 of word 0 is 1. For an engine-owned descriptor, words 0 to 3 are read from offsets 0, 4, 8 and 12. Word 1 bits 10:0 give the buffer size in bytes, word 2 the buffer byte address, and word 3 the byte address of the next descriptor. Frame words are written to consecutive word addresses from the start of the buffer. The stream is never accepted while a memory request is pending.
- R3: When a buffer fills before the frame ends, the engine writes word 0 of that descriptor with bit 31 cleared and bit 8 cleared. Bit 9 is set only if this descriptor held the first word of the frame. The frame continues in the descriptor named by word 3.
- R4: The descriptor that holds the last word of a frame gets word 0 written as follows: bit 31 = 0, bit 8 = 1, bit 9 = 1 if it also held the first word, and bits 29:16 = the frame length in bytes (4 × words). All other bits are 0.
- R5: `flag_ri` becomes 1 after the word 0 write that closes a frame's last descriptor, and it stays 1 until it is cleared.
- R6: Reading a word 0 with bit 31 = 0 sets `flag_ru` and suspends the engine. While suspended, `in_ready` is 0 and nothing is written to the buffer of that descriptor.
- R7: A frame that arrives while the engine is suspended causes word 0 of the same descriptor to be read again. If that word is now engine-owned, the frame is received and closed as in R4.
- R8: If the re-read word 0 is still host-owned, the engine accepts every word of the frame up to `in_last` with no memory write, increments `missed_count` by one, and suspends again.
- R9: After a frame is closed, the next descriptor is fetched without waiting for further input. A host-owned next descriptor therefore raises `flag_ru` before another frame is offered.
- R10: A memory request keeps `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` unchanged until the cycle in which `mem_ack` is 1.
- R11: Bit 0 of `flag_clr` clears `flag_ri` and bit 1 clears `flag_ru`. Each clear takes effect one cycle after it is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_enable | input | 1 | Receive run control |
| ring_base | input | AW | Byte address of the first descriptor |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | AW | Byte address of the word accessed |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request accepted; read data valid in the same cycle |
| mem_rdata | input | 32 | Read data |
| in_valid | input | 1 | Stream word valid |
| in_data | input | 32 | Stream word |
| in_first | input | 1 | First word of a frame |
| in_last | input | 1 | Last word of a frame |
| in_ready | output | 1 | Stream word accepted when in_valid is also 1 |
| flag_ri | output | 1 | Sticky frame-received flag |
| flag_ru | output | 1 | Sticky buffer-unavailable flag |
| flag_clr | input | 2 | Write-one-to-clear for the flags |
| missed_count | output | CW | Count of discarded frames |

## Verification
The bench sends frames of every length from one to five words through descriptors with two-word buffers. Each frame length therefore splits across buffers differently, and every word 0 written back is compared with an arithmetic model. A design that miscounts buffer fill would spill data into the next buffer or set the wrong segment bits. A design that measured length per segment rather than per frame would report short lengths.

The memory stalls its acknowledgements in a pseudo-random pattern, so an address that changes before the acknowledgement shows up as corrupted data. After the chain is used up, the bench offers a frame to the suspended engine twice. The first time the descriptor is still host-owned, and a sentinel in its buffer must survive while the missed count rises. The second time the descriptor has been handed over, and an engine that skipped the re-read would lose that frame. The bench also restarts the engine with a new base address, which catches a design that keeps its old descriptor pointer.

// File: rtl/rx_desc_dma.sv
module rx_desc_dma #(
  parameter int AW = 16,
  parameter int SW = 11,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_enable,
  input  logic [AW-1:0] ring_base,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic          mem_ack,
  input  logic [31:0]   mem_rdata,
  input  logic          in_valid,
  input  logic [31:0]   in_data,
  input  logic          in_first,
  input  logic          in_last,
  output logic          in_ready,
  output logic          flag_ri,
  output logic          flag_ru,
  input  logic [1:0]    flag_clr,
  output logic [CW-1:0] missed_count
);

  localparam int LW = 14;
  localparam int FW = LW - 2;

  typedef enum logic [3:0] {
    S_IDLE, S_F0, S_F1, S_F2, S_F3, S_RDY, S_WR, S_CLS, S_SUSP, S_DROP
  } st_t;

  st_t           state;
  logic [AW-1:0] cur, nxt, bufa;
  logic [SW-1:0] size, off;
  logic [FW-1:0] flen;
  logic [31:0]   dbuf;
  logic          lastw, seg_first, in_frame, pend;
  logic          ri, ru;
  logic [CW-1:0] missed;

  logic          ack;
  logic [SW-1:0] next_off;
  logic [31:0]   close_word;
  logic          unused_rdata;

  assign mem_req  = state inside {S_F0, S_F1, S_F2, S_F3, S_WR, S_CLS};
  assign mem_we   = state inside {S_WR, S_CLS};
  assign ack      = mem_req && mem_ack;
  assign in_ready = state inside {S_RDY, S_DROP};
  assign next_off = off + SW'(4);
  assign close_word = {2'b00, lastw ? {flen, 2'b00} : LW'(0), 6'b0, seg_first, lastw, 8'h00};
  assign mem_wdata  = (state == S_CLS) ? close_word : dbuf;
  assign flag_ri = ri;
  assign flag_ru = ru;
  assign missed_count = missed;
  assign unused_rdata = ^mem_rdata;

  always_comb begin
    case (state)
      S_F0:    mem_addr = cur;
      S_F1:    mem_addr = cur + AW'(4);
      S_F2:    mem_addr = cur + AW'(8);
      S_F3:    mem_addr = cur + AW'(12);
      S_WR:    mem_addr = bufa + {{(AW-SW){1'b0}}, off};
      S_CLS:   mem_addr = cur;
      default: mem_addr = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      cur <= '0; nxt <= '0; bufa <= '0;
      size <= '0; off <= '0; flen <= '0; dbuf <= '0;
      lastw <= 1'b0; seg_first <= 1'b0; in_frame <= 1'b0; pend <= 1'b0;
      ri <= 1'b0; ru <= 1'b0; missed <= '0;
    end else begin
      ri <= ri & ~flag_clr[0];
      ru <= ru & ~flag_clr[1];
      case (state)
        S_IDLE: if (rx_enable) begin
          cur <= ring_base;
          pend <= 1'b0;
          in_frame <= 1'b0;
          state <= S_F0;
        end
        S_F0: if (ack) begin
          pend <= 1'b0;
          if (mem_rdata[31]) state <= S_F1;
          else begin
            ru <= 1'b1;
            in_frame <= 1'b0;
            state <= (pend || in_frame) ? S_DROP : S_SUSP;
          end
        end
        S_F1: if (ack) begin
          size <= mem_rdata[SW-1:0];
          state <= S_F2;
        end
        S_F2: if (ack) begin
          bufa <= mem_rdata[AW-1:0];
          state <= S_F3;
        end
        S_F3: if (ack) begin
          nxt <= mem_rdata[AW-1:0];
          off <= '0;
          seg_first <= 1'b0;
          state <= S_RDY;
        end
        S_RDY: if (in_valid) begin
          dbuf <= in_data;
          lastw <= in_last;
          if (in_first) begin
            in_frame <= 1'b1;
            seg_first <= 1'b1;
            flen <= FW'(1);
          end else flen <= flen + 1'b1;
          state <= S_WR;
        end else if (!rx_enable && !in_frame) state <= S_IDLE;
        S_WR: if (ack) begin
          off <= next_off;
          state <= (lastw || next_off >= size) ? S_CLS : S_RDY;
        end
        S_CLS: if (ack) begin
          if (lastw) begin
            ri <= 1'b1;
            in_frame <= 1'b0;
          end
          cur <= nxt;
          state <= S_F0;
        end
        S_SUSP: if (!rx_enable) state <= S_IDLE;
          else if (in_valid) begin
            pend <= 1'b1;
            state <= S_F0;
          end
        S_DROP: if (in_valid && in_last) begin
          missed <= missed + 1'b1;
          state <= S_SUSP;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/rx_desc_dma_chk.sv
module rx_desc_dma_chk #(
  parameter int AW = 16,
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [31:0]   mem_wdata,
  input logic          mem_ack,
  input logic [31:0]   mem_rdata,
  input logic          in_valid,
  input logic          in_ready,
  input logic          in_last,
  input logic          flag_ri,
  input logic          flag_ru,
  input logic [CW-1:0] missed_count
);

  assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata));

  assert_no_accept_during_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !mem_req);

  assert_ri_after_close_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_ri) |-> $past(mem_req && mem_we && mem_ack));

  assert_ru_on_host_word_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_ru) |-> $past(mem_req && !mem_we && mem_ack && !mem_rdata[31]));

  assert_missed_on_frame_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(missed_count) |-> $past(in_valid && in_ready && in_last) && !$past(mem_req));

endmodule

bind rx_desc_dma rx_desc_dma_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
  .mem_rdata(mem_rdata), .in_valid(in_valid), .in_ready(in_ready),
  .in_last(in_last), .flag_ri(flag_ri), .flag_ru(flag_ru),
  .missed_count(missed_count)
);

// File: tb/sim_rx_desc_dma.sv
`timescale 1ns/1ps
module sim_rx_desc_dma;
  localparam int AW = 16;
  localparam int CW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_enable = 1'b0;
  logic [AW-1:0] ring_base = '0;
  logic mem_req, mem_we, mem_ack;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;
  logic in_valid = 1'b0, in_first = 1'b0, in_last = 1'b0;
  logic [31:0] in_data = '0;
  logic in_ready, flag_ri, flag_ru;
  logic [1:0] flag_clr = 2'b00;
  logic [CW-1:0] missed_count;

  logic [31:0] mem [0:1023];
  logic [7:0] lfsr;
  logic bk_we = 1'b0;
  logic [9:0] bk_addr = '0;
  logic [31:0] bk_data = '0;
  logic en_q, cap_wait;
  logic [AW-1:0] first_rd;
  logic p_pend, p_we;
  logic [AW-1:0] p_addr;
  logic [31:0] p_wdata;
  int hold_viol;
  int nchk = 0, nfail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  assign mem_ack = mem_req && (lfsr[1:0] != 2'b00);
  assign mem_rdata = mem[mem_addr[11:2]];

  rx_desc_dma #(.AW(AW), .SW(11), .CW(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .rx_enable(rx_enable), .ring_base(ring_base),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .in_valid(in_valid), .in_data(in_data), .in_first(in_first), .in_last(in_last),
    .in_ready(in_ready), .flag_ri(flag_ri), .flag_ru(flag_ru), .flag_clr(flag_clr),
    .missed_count(missed_count)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      lfsr <= 8'h5A; en_q <= 1'b0; cap_wait <= 1'b0; first_rd <= '1;
      p_pend <= 1'b0; p_we <= 1'b0; p_addr <= '0; p_wdata <= '0; hold_viol <= 0;
    end else begin
      lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      if (mem_req && mem_we && mem_ack) mem[mem_addr[11:2]] <= mem_wdata;
      en_q <= rx_enable;
      if (rx_enable && !en_q) cap_wait <= 1'b1;
      else if (cap_wait && mem_req && mem_ack && !mem_we) begin
        first_rd <= mem_addr; cap_wait <= 1'b0;
      end
      if (p_pend && !(mem_req && mem_we == p_we && mem_addr == p_addr && mem_wdata == p_wdata))
        hold_viol <= hold_viol + 1;
      p_pend <= mem_req && !mem_ack;
      p_we <= mem_we; p_addr <= mem_addr; p_wdata <= mem_wdata;
    end
    if (bk_we) mem[bk_addr] <= bk_data;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic poke(input int a, input logic [31:0] d);
    bk_we = 1'b1; bk_addr = 10'(a >> 2); bk_data = d;
    @(negedge clk);
    bk_we = 1'b0;
  endtask

  task automatic send_frame(input int fid, input int n);
    for (int i = 0; i < n; i++) begin
      in_valid = 1'b1; in_data = 32'hA000_0000 | 32'(fid << 8) | 32'(i);
      in_first = (i == 0); in_last = (i == n - 1);
      #1;
      while (!in_ready) begin @(negedge clk); #1; end
      @(negedge clk);
    end
    in_valid = 1'b0; in_first = 1'b0; in_last = 1'b0;
  endtask

  task automatic pulse_clr(input logic [1:0] c);
    flag_clr = c; @(negedge clk); flag_clr = 2'b00; @(negedge clk);
  endtask

  function automatic logic [31:0] dw(input int fid, input int i);
    return 32'hA000_0000 | 32'(fid << 8) | 32'(i);
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin : main
    int d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("reset in_ready", 32'(in_ready), 0);
    chk("reset mem_req", 32'(mem_req), 0);
    chk("reset R5 flag_ri", 32'(flag_ri), 0);
    chk("reset R6 flag_ru", 32'(flag_ru), 0);
    chk("reset R8 missed", 32'(missed_count), 0);

    for (int i = 0; i < 12; i++) begin
      poke(16*i, (i < 9) ? 32'h8000_0000 : 32'h0);
      poke(16*i + 4, 32'd8);
      poke(16*i + 8, 32'h400 + 32*i);
      poke(16*i + 12, 32'(16*(i + 1)));
      poke(32'h400 + 32*i, 32'hDEAD_0000 | 32'(i));
      poke(32'h404 + 32*i, 32'hBEEF_0000 | 32'(i));
    end

    ring_base = '0;
    rx_enable = 1'b1;
    repeat (40) @(negedge clk);
    chk("R1 first read at base", 32'(first_rd), 32'h0);
    chk("R6 no early RU", 32'(flag_ru), 0);
    for (int f = 0; f < 5; f++) begin
      send_frame(f, f + 1);
      repeat (5) @(negedge clk);
    end
    repeat (60) @(negedge clk);

    d = 0;
    for (int f = 0; f < 5; f++) begin
      int len = f + 1;
      int idx = 0;
      while (idx < len) begin
        int seg = (len - idx < 2) ? len - idx : 2;
        bit fs = (idx == 0);
        bit ls = (idx + seg == len);
        logic [31:0] e = (ls ? 32'(len * 4) << 16 : 32'h0) | (fs ? 32'h200 : 0) | (ls ? 32'h100 : 0);
        chk(ls ? "R4 last desc word0" : "R3 full desc word0", mem[(16*d) >> 2], e);
        for (int k = 0; k < seg; k++)
          chk("R2 buffer data", mem[(32'h400 + 32*d + 4*k) >> 2], dw(f, idx + k));
        idx += seg;
        d++;
      end
    end
    chk("R5 RI set", 32'(flag_ri), 1);
    chk("R9 prefetch raised RU", 32'(flag_ru), 1);
    chk("R6 suspended not ready", 32'(in_ready), 0);
    chk("R6 host desc untouched", mem[9*4], 32'h0);

    pulse_clr(2'b11);
    chk("R11 RI cleared", 32'(flag_ri), 0);
    chk("R11 RU cleared", 32'(flag_ru), 0);

    send_frame(7, 3);
    repeat (30) @(negedge clk);
    chk("R8 missed count", 32'(missed_count), 1);
    chk("R8 RU again", 32'(flag_ru), 1);
    chk("R8 buffer sentinel 0", mem[(32'h400 + 32*9) >> 2], 32'hDEAD_0009);
    chk("R8 buffer sentinel 1", mem[(32'h404 + 32*9) >> 2], 32'hBEEF_0009);
    chk("R8 desc kept", mem[9*4], 32'h0);
    chk("R5 RI not set by drop", 32'(flag_ri), 0);

    pulse_clr(2'b10);
    poke(16*9, 32'h8000_0000);
    send_frame(8, 2);
    repeat (60) @(negedge clk);
    chk("R7 refetched desc word0", mem[9*4], 32'h0008_0300);
    chk("R7 data 0", mem[(32'h400 + 32*9) >> 2], dw(8, 0));
    chk("R7 data 1", mem[(32'h404 + 32*9) >> 2], dw(8, 1));
    chk("R7 missed unchanged", 32'(missed_count), 1);
    chk("R7 RI set", 32'(flag_ri), 1);
    chk("R9 next desc host-owned RU", 32'(flag_ru), 1);

    rx_enable = 1'b0;
    repeat (5) @(negedge clk);
    pulse_clr(2'b11);
    poke(16*11, 32'h8000_0000);
    poke(16*11 + 12, 32'h0);
    ring_base = AW'(16*11);
    rx_enable = 1'b1;
    repeat (40) @(negedge clk);
    chk("R1 restart read at new base", 32'(first_rd), 32'(16*11));
    send_frame(9, 1);
    repeat (40) @(negedge clk);
    chk("R4 single word desc", mem[11*4], 32'h0004_0300);
    chk("R2 single word data", mem[(32'h400 + 32*11) >> 2], dw(9, 0));
    chk("R5 RI after restart", 32'(flag_ri), 1);
    chk("R10 request held until ack", 32'(hold_viol), 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule